// File: doc/BRIEF.md
# Signed Reciprocal-Multiply Divider

This block divides a stream of two's-complement N-bit operands by one signed divisor that stays fixed for a long run of operands, and rounds each quotient toward zero. No divider is used per operand. Loading a divisor starts a setup pass that works out three values: an N-bit signed multiplier, one arithmetic shift count, and a mask that holds the divisor's sign. The setup pass uses a bit-serial restoring divider and ends with a one-cycle done pulse. After that, each accepted operand passes through a signed multiply-high, an add, an arithmetic shift and two sign corrections, and the quotient is registered onto a valid/ready output stream.

The multiplier depends only on the divisor's magnitude. Rounding toward zero comes from subtracting the operand's sign mask. The divisor's sign is applied last, with an XOR and a subtract. The most negative divisor needs no special case: its magnitude still fits in N unsigned bits. A zero divisor moves the block to a fault state. That state raises a sticky flag and refuses operands until a non-zero divisor is loaded.

States and transitions of the control machine: ST_IDLE (no divisor yet), ST_SETUP (multiplier being computed), ST_RUN (operands accepted) and ST_FAULT (zero divisor held).
- IDLE, RUN or FAULT go to SETUP on a load with a non-zero divisor.
- IDLE, RUN or FAULT go to FAULT on a load with a zero divisor.
- SETUP goes to RUN when the setup pass finishes.
- A load is ignored while the block is in SETUP.

Top module: `recip_sdiv`

## Requirements
- R1: After reset, setup_done, dz_err, in_ready and out_valid are all low.
- R2: After a load with a non-zero divisor, setup_done pulses for one cycle no more than 2N+1 cycles later. in_ready stays low until that pulse and is high the cycle after it.
- R3: For a divisor magnitude D > 1, the shift count is the index of the highest set bit of D-1, which is at most N-2. The multiplier is floor(2^(N+shift)/D)+1 kept to N bits, and its top bit is set. For D = 1 the shift is 0 and the multiplier is 1.
- R4: For every non-zero divisor d and every operand a, out_quot equals a/d rounded toward zero, taken modulo 2^N. A zero operand gives a zero quotient.
- R5: With the most negative divisor (only the top bit set), the quotient is 1 for the most negative operand and 0 for every other operand.
- R6: The most negative operand divided by -1 returns the most negative value. dz_err stays low.
- R7: A load with a zero divisor sets dz_err, gives no setup_done and holds in_ready low. dz_err stays set until a load with a non-zero divisor clears it.
- R8: While out_valid is high and out_ready is low, out_quot does not change and in_ready is low. Quotients come out in the order their operands were accepted.
- R9: A load made while setup is in progress has no effect. The quotients that follow use the divisor that started the setup.
- R10: An operand accepted on a clock edge (in_valid and in_ready both high) has its quotient on out_quot, with out_valid high, right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load strobe for a new divisor |
| cfg_divisor | input | N | Signed divisor sampled with cfg_load |
| setup_done | output | 1 | One-cycle pulse when the divisor's parameters are ready |
| dz_err | output | 1 | Sticky flag: last loaded divisor was zero |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Operand can be accepted |
| in_operand | input | N | Signed dividend |
| out_valid | output | 1 | Quotient valid |
| out_ready | input | 1 | Downstream accepts the quotient |
| out_quot | output | N | Signed quotient, truncated toward zero |

## Verification
The assertions check these properties on every cycle:
- the range of the shift count and the top bit of the multiplier each time setup finishes;
- that a fault refuses operands and keeps its flag;
- that a quotient is held under back-pressure and appears one cycle after acceptance;
- that a zero operand yields zero.

Arithmetic correctness can only be shown by the bench's scenarios. The bench sweeps every non-zero divisor against every operand at N = 8 and compares each result with truncating division computed in the bench. The scenarios also cover the setup latency, the ignored load during setup, recovery from a zero divisor, and the most-negative corner cases.

// File: rtl/recip_div_pkg.sv
package recip_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_RUN   = 2'd2,
        ST_FAULT = 2'd3
    } div_state_e;

endpackage

// File: rtl/recip_param_gen.sv
module recip_param_gen #(
    parameter int N = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [N-1:0]           divisor,
    output logic                   done,
    output logic                   busy,
    output logic [N-1:0]           mult,
    output logic [$clog2(N)-1:0]   shamt,
    output logic [N-1:0]           dmask
);
    localparam int SHW   = $clog2(N);
    localparam int QBITS = 2 * N - 1;
    localparam int CW    = $clog2(2 * N);

    logic [N-1:0]   mag_c;
    logic [N-1:0]   magm1_c;
    logic [SHW-1:0] sh_c;

    logic [N-1:0]   dm_r;
    logic [SHW-1:0] sh_r;
    logic           unit_r;
    logic [CW-1:0]  cnt_r;
    logic [N-1:0]   rem_r;
    logic [N-1:0]   quot_r;

    logic           bit_c;
    logic [N:0]     trial_c;
    logic           ge_c;
    logic [N-1:0]   quot_nx;
    logic [N-1:0]   rem_nx;

    // Divisor magnitude; the most negative value maps to 2^(N-1) unsigned.
    always_comb begin
        mag_c   = divisor[N-1] ? (~divisor + 1'b1) : divisor;
        magm1_c = mag_c - 1'b1;
        sh_c    = '0;
        for (int i = 0; i < N; i++) begin
            if (magm1_c[i]) sh_c = SHW'(i);
        end
    end

    // One restoring step over the dividend 2^(N+sh), most significant bit first.
    always_comb begin
        bit_c   = ((cnt_r - CW'(1)) == (CW'(N) + CW'(sh_r)));
        trial_c = {rem_r, bit_c};
        ge_c    = (trial_c >= {1'b0, dm_r});
        rem_nx  = ge_c ? N'(trial_c - {1'b0, dm_r}) : trial_c[N-1:0];
        quot_nx = {quot_r[N-2:0], ge_c};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            dm_r   <= '0;
            sh_r   <= '0;
            unit_r <= 1'b0;
            cnt_r  <= '0;
            rem_r  <= '0;
            quot_r <= '0;
            mult   <= '0;
            shamt  <= '0;
            dmask  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy   <= 1'b1;
                dm_r   <= mag_c;
                sh_r   <= sh_c;
                unit_r <= (mag_c == N'(1));
                cnt_r  <= CW'(QBITS);
                rem_r  <= '0;
                quot_r <= '0;
                dmask  <= {N{divisor[N-1]}};
            end else if (busy) begin
                if (unit_r) begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    mult  <= N'(1);
                    shamt <= '0;
                end else begin
                    rem_r  <= rem_nx;
                    quot_r <= quot_nx;
                    cnt_r  <= cnt_r - CW'(1);
                    if (cnt_r == CW'(1)) begin
                        busy  <= 1'b0;
                        done  <= 1'b1;
                        mult  <= quot_nx + 1'b1;
                        shamt <= sh_r;
                    end
                end
            end
        end
    end

    assert_shift_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (shamt <= SHW'(N - 2)));

    assert_mult_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !unit_r) |-> mult[N-1]);

    assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

endmodule

// File: rtl/recip_quot_unit.sv
module recip_quot_unit #(
    parameter int N = 16
) (
    input  logic [N-1:0]         operand,
    input  logic [N-1:0]         mult,
    input  logic [$clog2(N)-1:0] shamt,
    input  logic [N-1:0]         dmask,
    output logic [N-1:0]         quot
);
    logic signed [N-1:0]   sa;
    logic signed [N-1:0]   sm;
    logic signed [2*N-1:0] prod;
    logic [N-1:0]          hi;
    logic [N-1:0]          q0;
    logic signed [N-1:0]   sft;
    logic [N-1:0]          amask;
    logic [N-1:0]          q1;

    always_comb begin
        sa    = $signed(operand);
        sm    = $signed(mult);
        prod  = sa * sm;
        hi    = prod[2*N-1:N];
        q0    = operand + hi;
        sft   = $signed(q0) >>> shamt;
        amask = {N{operand[N-1]}};
        q1    = sft - amask;
        quot  = (q1 ^ dmask) - dmask;
    end

endmodule

// File: rtl/recip_sdiv.sv
module recip_sdiv
    import recip_div_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_load,
    input  logic [N-1:0] cfg_divisor,
    output logic         setup_done,
    output logic         dz_err,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [N-1:0] in_operand,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [N-1:0] out_quot
);
    localparam int SHW = $clog2(N);

    div_state_e     state_q, state_d;
    logic           load_ok;
    logic           nz_div;
    logic           pg_start;
    logic           pg_done;
    logic           pg_busy;
    logic [N-1:0]   pg_mult;
    logic [SHW-1:0] pg_shamt;
    logic [N-1:0]   pg_dmask;
    logic [N-1:0]   quot_c;
    logic           accept;

    assign nz_div   = |cfg_divisor;
    assign load_ok  = cfg_load && (state_q != ST_SETUP);
    assign pg_start = load_ok && nz_div;

    recip_param_gen #(.N(N)) u_param_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (pg_start),
        .divisor (cfg_divisor),
        .done    (pg_done),
        .busy    (pg_busy),
        .mult    (pg_mult),
        .shamt   (pg_shamt),
        .dmask   (pg_dmask)
    );

    recip_quot_unit #(.N(N)) u_quot_unit (
        .operand (in_operand),
        .mult    (pg_mult),
        .shamt   (pg_shamt),
        .dmask   (pg_dmask),
        .quot    (quot_c)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_RUN, ST_FAULT: begin
                if (load_ok) state_d = nz_div ? ST_SETUP : ST_FAULT;
            end
            ST_SETUP: begin
                if (pg_done) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        in_ready   = (state_q == ST_RUN) && (!out_valid || out_ready);
        dz_err     = (state_q == ST_FAULT);
        setup_done = pg_done;
    end

    assign accept = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_quot  <= '0;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_quot  <= quot_c;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assert_fault_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dz_err |-> !in_ready);

    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dz_err && !cfg_load) |=> dz_err);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_quot)));

    assert_setup_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pg_busy |-> !in_ready);

    assert_result_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

    assert_zero_operand_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (in_operand == '0)) |=> (out_quot == '0));

endmodule

// File: tb/test_recip_sdiv.sv
module test_recip_sdiv;
    localparam int N       = 8;
    localparam int CLK_PER = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_load = 1'b0;
    logic [N-1:0] cfg_divisor = '0;
    logic         setup_done;
    logic         dz_err;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [N-1:0] in_operand = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [N-1:0] out_quot;

    int total = 0;
    int bad   = 0;

    always #(CLK_PER / 2) clk = ~clk;

    recip_sdiv #(.N(N)) i_recip_sdiv (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_divisor(cfg_divisor),
        .setup_done(setup_done), .dz_err(dz_err), .in_valid(in_valid),
        .in_ready(in_ready), .in_operand(in_operand), .out_valid(out_valid),
        .out_ready(out_ready), .out_quot(out_quot)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] ref_div(input int a, input int d);
        int q;
        q = a / d;
        return q[N-1:0];
    endfunction

    // Load a divisor; return number of cycles until setup_done (or -1).
    task automatic load_div(input int d, output int lat);
        @(negedge clk);
        cfg_load    = 1'b1;
        cfg_divisor = d[N-1:0];
        @(negedge clk);
        cfg_load = 1'b0;
        lat = -1;
        for (int c = 1; c <= 2 * N + 4; c++) begin
            if (setup_done) begin
                lat = c;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic sweep(input int d);
        int lat;
        load_div(d, lat);
        chk(lat > 0 && lat <= 2 * N + 1, "R2 setup latency", lat, 2 * N + 1);
        @(negedge clk);
        chk(in_ready == 1'b1, "R2 ready after setup", int'(in_ready), 1);
        for (int a = -(1 << (N - 1)); a < (1 << (N - 1)); a++) begin
            logic [N-1:0] e;
            e = ref_div(a, d);
            in_valid   = 1'b1;
            in_operand = a[N-1:0];
            @(negedge clk);
            if (d == -(1 << (N - 1)))
                chk(out_valid && out_quot == e, "R5 most negative divisor",
                    int'($signed(out_quot)), int'($signed(e)));
            else if (d == -1 && a == -(1 << (N - 1)))
                chk(out_valid && out_quot == e && !dz_err, "R6 min by -1 wraps",
                    int'($signed(out_quot)), int'($signed(e)));
            else
                chk(out_valid && out_quot == e, "R4 R10 quotient",
                    int'($signed(out_quot)), int'($signed(e)));
        end
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat;
        logic [N-1:0] held;
        repeat (3) @(negedge clk);
        chk(!setup_done && !dz_err && !in_ready && !out_valid, "R1 reset state",
            int'({setup_done, dz_err, in_ready, out_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!in_ready && !dz_err, "R1 idle after reset", int'({in_ready, dz_err}), 0);

        // R7: zero divisor
        load_div(0, lat);
        chk(lat == -1, "R7 no setup_done on zero", lat, -1);
        chk(dz_err && !in_ready, "R7 fault blocks", int'({dz_err, in_ready}), 2);
        in_valid = 1'b1;
        in_operand = 8'd5;
        repeat (3) @(negedge clk);
        chk(!out_valid && dz_err, "R7 operand refused, flag sticky",
            int'({out_valid, dz_err}), 1);
        in_valid = 1'b0;

        // R9: load during setup ignored; also clears the fault
        @(negedge clk);
        cfg_load = 1'b1;
        cfg_divisor = 8'd3;
        @(negedge clk);
        cfg_divisor = 8'd5;
        chk(!dz_err && !in_ready, "R7 fault cleared, R2 not ready in setup",
            int'({dz_err, in_ready}), 0);
        @(negedge clk);
        cfg_load = 1'b0;
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_operand = 8'd100;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && out_quot == 8'd33, "R9 load during setup ignored",
            int'(out_quot), 33);

        // R8: back-pressure
        load_div(-7, lat);
        @(negedge clk);
        out_ready  = 1'b0;
        in_valid   = 1'b1;
        in_operand = 8'd100;
        @(negedge clk);
        in_operand = 8'd50;
        held = out_quot;
        chk(out_valid && held == ref_div(100, -7), "R8 first result",
            int'($signed(held)), int'($signed(ref_div(100, -7))));
        repeat (3) begin
            @(negedge clk);
            chk(out_valid && out_quot == held && !in_ready, "R8 held under stall",
                int'($signed(out_quot)), int'($signed(held)));
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && out_quot == ref_div(50, -7), "R8 order after stall",
            int'($signed(out_quot)), int'($signed(ref_div(50, -7))));
        @(negedge clk);
        chk(!out_valid, "R8 drains", int'(out_valid), 0);

        // R3 R4 R5 R6: exhaustive sweep over all non-zero divisors
        for (int d = -(1 << (N - 1)); d < (1 << (N - 1)); d++) begin
            if (d != 0) sweep(d);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule